// File: doc/BRIEF.md
# Register-File Serial Target with Auto-Incrementing Word Pointer

This block is the bus-side front end of a small timekeeping register space. It answers on a two-wire I2C bus at one fixed 7-bit device address. Behind it sits a 64-byte register file: bytes 0 to 7 hold the clock and calendar registers, and bytes 8 to 63 are general storage. Both SCL and SDA are oversampled by the system clock through synchronizers. START and STOP are recognised in every state. The block shifts in the device address, the word address and the write data, drives ACK, and in read mode shifts register contents out onto SDA.

An internal word pointer chooses the register being accessed. A write transaction loads the pointer from the first byte and then stores each later byte, stepping the pointer after each one. A read returns bytes from the pointer onward. The pointer steps after a read byte only when the master acknowledges that byte, so a read that ends in NACK leaves the pointer on the last byte sent. A read that begins without a pointer write continues from wherever the pointer was left.

The serial side carries no valid/ready handshake. The master alone paces every bit. The block never stretches SCL and never applies back-pressure, so it must accept or present a bit within each SCL phase. It needs only a few system-clock cycles per SCL edge to do so. SDA is open-drain: `sda_oe` high pulls the line low.

Top module: `rtc_i2c_target`

## Requirements
- R1: After reset, SDA is released, the word pointer is 0, and all 64 register bytes read as 0x00.
- R2: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle.
- R3: The first byte after START is seven address bits, MSB first, followed by R/W in bit 0 (0 = write, 1 = read). A matching address is acknowledged by holding SDA low through the ninth clock. A non-matching address is not acknowledged, and the block drives nothing and stores nothing until the next START.
- R4: In a write transaction the byte after the address is a word address. Its low 6 bits are loaded into the pointer (bits 7:6 are ignored), and the byte is acknowledged.
- R5: Each later write byte is acknowledged and stored at the pointer, which then advances by one, wrapping from 63 to 0.
- R6: In a read transaction, data leaves MSB first, each bit placed on SDA after a falling SCL edge. The pointer advances only when the master answers a byte with ACK (SDA low on the ninth clock).
- R7: Sequential reading continues while the master acknowledges. After a master NACK the block releases SDA and ignores further clocks until START or STOP.
- R8: A read transaction with no word address before it returns data starting at the address currently in the pointer.
- R9: The block changes SDA only while the synchronized SCL is low.
- R10: A random read (a pointer write, then a repeated START and the address with R/W = 1) returns data starting at the newly written address.
- R11: A write byte cut short by START or STOP before its eighth bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
The bench goes after the pointer rules:
- A read that ends in NACK is followed by a current-address read. A design that steps the pointer on every byte returns the next byte instead of repeating the last one.
- A write that crosses address 63 checks the wrap. A design that does not wrap corrupts or loses the third byte.
- A word address with bit 6 set checks that only the low 6 bits reach the pointer.

It also checks the abort and ignore paths:
- A data byte is cut off by a repeated START, and another by a STOP. A design that commits a partly shifted byte shows nonzero data on the following read.
- A foreign address is followed by write bytes. A design that acknowledges it pulls SDA low or changes storage.
- Clocks are sent after a master NACK. A design that keeps transmitting pulls SDA low there.

A monitor flags any SDA change while SCL is high.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_q     = synced[1];
  assign sda_q     = synced[0];
  assign scl_rise  = synced[1] & ~prev_q[1];
  assign scl_fall  = ~synced[1] & prev_q[1];
  // Bus conditions: SDA edge while SCL stays high
  assign start_det = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
  assign stop_det  = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];
endmodule

// File: rtl/rtc_i2c_regfile.sv
module rtc_i2c_regfile #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         DEPTH       = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  rtc_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_s), .sda_q(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e        state_q, ack_next_q;
  logic [CW-1:0]     bitcnt_q;
  logic [BYTE_W-1:0] shift_q, byte_in, rdata;
  logic [AW-1:0]     ptr_q;
  logic              sda_oe_q, mack_q, we;

  assign byte_in = {shift_q[BYTE_W-2:0], sda_s};
  assign we = (state_q == ST_WDATA) && scl_rise && (bitcnt_q == LAST_BIT)
              && !start_det && !stop_det;

  rtc_i2c_regfile #(.DEPTH(DEPTH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr_q), .wdata(byte_in),
    .raddr(ptr_q), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      bitcnt_q   <= '0;
      shift_q    <= '0;
      ptr_q      <= '0;
      sda_oe_q   <= 1'b0;
      mack_q     <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_DEVADDR;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_DEVADDR: if (scl_rise) begin
          shift_q  <= byte_in;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            if (byte_in[7:1] == DEV_ADDR) begin
              state_q    <= ST_ACK;
              ack_next_q <= byte_in[0] ? ST_RDATA : ST_WADDR;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WADDR: if (scl_rise) begin
          shift_q  <= byte_in;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            ptr_q      <= byte_in[AW-1:0];
            state_q    <= ST_ACK;
            ack_next_q <= ST_WDATA;
          end
        end
        ST_WDATA: if (scl_rise) begin
          shift_q  <= byte_in;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            ptr_q      <= ptr_q + AW'(1);
            state_q    <= ST_ACK;
            ack_next_q <= ST_WDATA;
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!sda_oe_q) begin
            sda_oe_q <= 1'b1;
          end else begin
            bitcnt_q <= '0;
            if (ack_next_q == ST_RDATA) begin
              shift_q  <= rdata;
              sda_oe_q <= ~rdata[BYTE_W-1];
            end else begin
              sda_oe_q <= 1'b0;
            end
            state_q <= ack_next_q;
          end
        end
        ST_RDATA: if (scl_fall) begin
          if (bitcnt_q == LAST_BIT) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_RACK;
          end else begin
            bitcnt_q <= bitcnt_q + 1'b1;
            shift_q  <= shift_q << 1;
            sda_oe_q <= ~shift_q[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
            if (!sda_s) ptr_q <= ptr_q + AW'(1);
          end
          if (scl_fall) begin
            if (mack_q) begin
              shift_q  <= rdata;
              sda_oe_q <= ~rdata[BYTE_W-1];
              bitcnt_q <= '0;
              state_q  <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  // R9: the drive only moves in a cycle that followed a low synchronized SCL
  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !$past(scl_s));

  // R2: a START always restarts address reception
  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state_q == ST_DEVADDR);

  // R6: a master NACK on the ninth clock leaves the pointer untouched
  assert_ptr_hold_on_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACK && scl_rise && sda_s && !start_det && !stop_det)
      |=> ptr_q == $past(ptr_q));

  // R7 / R3: an idle target never pulls the line
  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> !sda_oe_q);

  // R5: exactly one store per received data byte
  assert_single_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
endmodule

// File: tb/rtc_i2c_target_test.sv
module rtc_i2c_target_test;
  localparam logic [6:0] DEV  = 7'h68;
  localparam logic [6:0] ALT  = 7'h50;
  localparam int HALF = 20;
  localparam int QTR  = 10;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic sda_oe;
  wire  sda_line = !(sda_m_low || sda_oe);

  int checks = 0;
  int failures = 0;
  int r9_viol = 0;
  bit done = 0;

  logic [7:0] ref_mem [64];
  int ref_ptr = 0;

  always #10 clk = ~clk;

  rtc_i2c_target #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R9 monitor: the target output must hold while SCL stays high
  logic prev_scl = 1'b1;
  logic prev_oe  = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) r9_viol++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    wait_clk(QTR); sda_m_low = !b;
    wait_clk(QTR); scl_m = 1'b1;
    wait_clk(QTR); r = sda_line;
    wait_clk(QTR); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m_low = 1'b1; wait_clk(HALF); scl_m = 1'b0;
  endtask

  task automatic bus_restart();
    wait_clk(QTR); sda_m_low = 1'b0;
    wait_clk(QTR); scl_m = 1'b1;
    wait_clk(HALF); sda_m_low = 1'b1;
    wait_clk(HALF); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(QTR); sda_m_low = 1'b1;
    wait_clk(QTR); scl_m = 1'b1;
    wait_clk(HALF); sda_m_low = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(!mack, r);
  endtask

  // reads n bytes against the model, ACKing all but the last
  task automatic read_loop(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      check(tag, d, ref_mem[ref_ptr]);
      if (i < n - 1) ref_ptr = (ref_ptr + 1) % 64;
    end
  endtask

  task automatic wr_txn(input logic [7:0] waddr, input int n,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic ack;
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R3 address ack (write)", ack, 1);
    send_byte(waddr, ack);       check("R4 word address ack", ack, 1);
    ref_ptr = waddr & 8'h3F;
    for (int i = 0; i < n; i++) begin
      send_byte(bytes[i], ack);  check("R5 data ack", ack, 1);
      ref_mem[ref_ptr] = bytes[i];
      ref_ptr = (ref_ptr + 1) % 64;
    end
    bus_stop();
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R3 address ack (read)", ack, 1);
    read_loop(n, tag);
    bus_stop();
  endtask

  task automatic rd_rand(input logic [7:0] waddr, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R3 address ack (write)", ack, 1);
    send_byte(waddr, ack);       check("R4 word address ack", ack, 1);
    ref_ptr = waddr & 8'h3F;
    bus_restart();
    send_byte({DEV, 1'b1}, ack); check("R10 address ack after repeated START", ack, 1);
    read_loop(n, tag);
    bus_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] d;
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(4);

    // R1: line released after reset
    check("R1 reset sda_oe", sda_oe, 0);
    // R1 / R8: current-address read from the reset pointer
    rd_cur(1, "R8 current read after reset (R1 zero)");

    // R4 / R5: multi-byte write
    wr_txn(8'h05, 3, 8'hA1, 8'hB2, 8'hC3);
    // R10 / R6: random read, ACK, ACK, NACK
    rd_rand(8'h05, 3, "R10 random sequential read");
    // R6 / R8: last byte was NACKed, so the pointer still points to it
    rd_cur(1, "R6 pointer held on NACK (R8)");

    // R5: wrap across 63 -> 0
    wr_txn(8'h3E, 3, 8'h11, 8'h22, 8'h33);
    check("R5 model pointer after wrap", ref_ptr, 1);
    rd_rand(8'h3F, 2, "R5 wrap readback");
    rd_cur(1, "R8 current read after wrap readback");

    // R4: bits 7:6 of the word address are ignored
    wr_txn(8'h47, 1, 8'h5A, 8'h00, 8'h00);
    rd_rand(8'h07, 1, "R4 low six bits of word address");

    // R3: foreign address gets no ACK and no store
    bus_start();
    send_byte({ALT, 1'b0}, ack); check("R3 foreign address not acked", ack, 0);
    send_byte(8'h05, ack);       check("R3 silent after mismatch", ack, 0);
    send_byte(8'hEE, ack);       check("R3 silent after mismatch", ack, 0);
    bus_stop();
    rd_rand(8'h05, 1, "R3 storage untouched by foreign address");

    // R7: clocks after a master NACK are ignored
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R3 address ack (read)", ack, 1);
    read_loop(1, "R7 byte before NACK");
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r);
      check("R7 line released after NACK", r, 1);
    end
    bus_stop();

    // R2 / R11: byte cut short by a repeated START
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R3 address ack (write)", ack, 1);
    send_byte(8'h0A, ack);       check("R4 word address ack", ack, 1);
    ref_ptr = 10;
    for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
    bus_restart();
    send_byte({DEV, 1'b1}, ack); check("R2 address ack after mid-byte START", ack, 1);
    read_loop(1, "R11 partial byte not stored (START)");
    bus_stop();

    // R11 / R2: byte cut short by a STOP
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R3 address ack (write)", ack, 1);
    send_byte(8'h0C, ack);       check("R4 word address ack", ack, 1);
    ref_ptr = 12;
    for (int i = 0; i < 5; i++) clk_bit(i[0], r);
    bus_stop();
    rd_cur(1, "R11 partial byte not stored (STOP)");

    // R2: after STOP the target stays quiet
    wait_clk(HALF);
    check("R2 released after STOP", sda_oe, 0);

    check("R9 no SDA change while SCL high", r9_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule